// File: doc/BRIEF.md
# Execute-Stage Operation Unit

This unit is the execute step of a five-stage 32-bit integer pipeline. It receives a two-bit instruction class from decode, the raw instruction word, the two register operands A and B, and the sequential next-PC (the fetch PC plus four). From these inputs it computes one 32-bit result and one branch-condition bit. Both values are captured in output registers that form the boundary to the memory stage.

The unit serves four instruction classes. A load or store produces a base-plus-offset effective address. Register-register and register-immediate arithmetic produce the selected ALU result. A branch produces its target address, which is the next-PC plus the word-scaled offset. A separate test checks whether A is zero and sets the condition bit. An encoding that the unit does not recognise produces a zero result and raises an illegal-operation bit. The output registers load only when the stage is enabled and is not being flushed.

Top module: `ex_stage_unit`

## Requirements
- R1: The immediate operand is instruction bits [15:0] sign-extended to 32 bits; a negative offset (bit 15 set) reduces the result.
- R2: Class 0 (memory reference) loads the result register with A + immediate (modulo 2^32), and the illegal bit is 0.
- R3: Class 1 (register-register) selects by function field bits [5:0]. 0x20 gives A+B, 0x22 gives A-B, 0x24 gives A&B, 0x25 gives A|B, 0x26 gives A^B, and 0x2A gives signed A<B as 1 or 0. 0x00 gives B shifted left logically, and 0x02 gives B shifted right logically, each by the shift field bits [10:6].
- R4: Class 2 (register-immediate) selects by opcode bits [31:26]. 0x08 gives A+imm, 0x0C gives A&imm, 0x0D gives A|imm, 0x0E gives A^imm, and 0x0A gives signed A<imm as 1 or 0.
- R5: Class 3 (branch) loads the result register with next-PC + (immediate << 2), modulo 2^32, and the illegal bit is 0.
- R6: For class 3 the condition bit is 1 exactly when A equals zero; for every other class the condition bit is 0.
- R7: Any function code in class 1, or opcode in class 2, that is not listed in R3 or R4 loads a zero result and sets the illegal bit. All listed codes clear the illegal bit.
- R8: The result, condition and illegal registers load only in a cycle with enable=1 and flush=0; in any other cycle all three keep their values.
- R9: With the synchronous active-low reset asserted at a clock edge, all three output registers become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Stage advance enable |
| flush | input | 1 | Suppresses the register update this cycle |
| op_class | input | 2 | 0 memory, 1 reg-reg, 2 reg-imm, 3 branch |
| instr | input | 32 | Instruction word (opcode, shift and function fields, immediate) |
| opnd_a | input | 32 | Operand A (base register / first source) |
| opnd_b | input | 32 | Operand B (second source) |
| npc | input | 32 | Sequential next PC |
| alu_out_q | output | 32 | Registered result |
| cond_q | output | 1 | Registered branch condition |
| illegal_q | output | 1 | Registered unrecognised-encoding flag |

## Verification
The assertions assume that the class, instruction word and operands are stable and known around each clock edge. They also assume that enable and flush are driven to defined levels whenever reset is released, because each property compares a register with the inputs sampled one edge earlier. The stimulus changes every input only on the falling clock edge. It mixes directed corner values (zero and sign-boundary operands, negative offsets, wrap-around targets) with pseudo-random operands. The random codes are drawn from the legal set plus a few illegal ones, and enable and flush toggle so that hold cycles fall between loads.

// File: rtl/ex_pkg.sv
// Package: shared class type, field positions and operation codes for the
// execute-stage unit. Assumes a 32-bit instruction word.
package ex_pkg;
    typedef enum logic [1:0] {
        CLS_MEM = 2'd0,
        CLS_RR  = 2'd1,
        CLS_RI  = 2'd2,
        CLS_BR  = 2'd3
    } op_class_e;

    localparam int INSTR_W   = 32;
    localparam int IMM_W     = 16;
    localparam int CODE_W    = 6;
    localparam int OPC_LSB   = 26;
    localparam int SHF_LSB   = 6;
    localparam int FN_LSB    = 0;

    localparam logic [CODE_W-1:0] FN_ADD = 6'h20;
    localparam logic [CODE_W-1:0] FN_SUB = 6'h22;
    localparam logic [CODE_W-1:0] FN_AND = 6'h24;
    localparam logic [CODE_W-1:0] FN_OR  = 6'h25;
    localparam logic [CODE_W-1:0] FN_XOR = 6'h26;
    localparam logic [CODE_W-1:0] FN_SLT = 6'h2A;
    localparam logic [CODE_W-1:0] FN_SLL = 6'h00;
    localparam logic [CODE_W-1:0] FN_SRL = 6'h02;

    localparam logic [CODE_W-1:0] OP_ADDI = 6'h08;
    localparam logic [CODE_W-1:0] OP_ANDI = 6'h0C;
    localparam logic [CODE_W-1:0] OP_ORI  = 6'h0D;
    localparam logic [CODE_W-1:0] OP_XORI = 6'h0E;
    localparam logic [CODE_W-1:0] OP_SLTI = 6'h0A;
endpackage

// File: rtl/ex_imm_ext.sv
// Module: sign-extends the low immediate field of the instruction word to the
// datapath width. Assumes XLEN >= IMM_W.
module ex_imm_ext #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm_raw,
    output logic [XLEN-1:0]  imm_sx
);
    localparam int PAD_W = XLEN - IMM_W;

    // Replicate the immediate sign bit into the upper bits.
    always_comb begin
        imm_sx = {{PAD_W{imm_raw[IMM_W-1]}}, imm_raw};
    end
endmodule

// File: rtl/ex_alu_core.sv
// Module: computes the result for memory, reg-reg and reg-imm classes and
// flags unknown codes. Assumes the branch class is resolved elsewhere.
module ex_alu_core
    import ex_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_class_e              cls,
    input  logic [CODE_W-1:0]      fn_code,
    input  logic [CODE_W-1:0]      opc_code,
    input  logic [$clog2(XLEN)-1:0] shamt,
    input  logic [XLEN-1:0]        a,
    input  logic [XLEN-1:0]        b,
    input  logic [XLEN-1:0]        imm,
    output logic [XLEN-1:0]        result,
    output logic                   bad_code
);
    localparam logic [XLEN-1:0] ZERO = '0;
    localparam logic [XLEN-1:0] ONE  = XLEN'(1);

    logic [XLEN-1:0] slt_ab;
    logic [XLEN-1:0] slt_ai;

    // Signed less-than results for both source pairs.
    always_comb begin
        slt_ab = ($signed(a) < $signed(b))   ? ONE : ZERO;
        slt_ai = ($signed(a) < $signed(imm)) ? ONE : ZERO;
    end

    // Select the operation from the class and the relevant code field.
    always_comb begin
        result   = ZERO;
        bad_code = 1'b0;
        unique case (cls)
            CLS_MEM: result = a + imm;
            CLS_RR: begin
                case (fn_code)
                    FN_ADD:  result = a + b;
                    FN_SUB:  result = a - b;
                    FN_AND:  result = a & b;
                    FN_OR:   result = a | b;
                    FN_XOR:  result = a ^ b;
                    FN_SLT:  result = slt_ab;
                    FN_SLL:  result = b << shamt;
                    FN_SRL:  result = b >> shamt;
                    default: bad_code = 1'b1;
                endcase
            end
            CLS_RI: begin
                case (opc_code)
                    OP_ADDI: result = a + imm;
                    OP_ANDI: result = a & imm;
                    OP_ORI:  result = a | imm;
                    OP_XORI: result = a ^ imm;
                    OP_SLTI: result = slt_ai;
                    default: bad_code = 1'b1;
                endcase
            end
            default: result = ZERO;
        endcase
    end
endmodule

// File: rtl/ex_branch_unit.sv
// Module: forms the branch target from next-PC and the word-scaled offset and
// tests operand A for zero. Assumes 4-byte instructions.
module ex_branch_unit #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] npc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] a,
    output logic [XLEN-1:0] target,
    output logic            a_is_zero
);
    localparam int WORD_SHIFT = 2;

    // Target adder and zero detector, independent of the main ALU.
    always_comb begin
        target    = npc + (imm << WORD_SHIFT);
        a_is_zero = (a == '0);
    end
endmodule

// File: rtl/ex_stage_unit.sv
// Module: execute-stage top. Combines the ALU core and branch unit and holds
// the result, condition and illegal flag in registers toward the memory stage.
// Assumes inputs are stable at the rising edge; synchronous active-low reset.
module ex_stage_unit
    import ex_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            flush,
    input  logic [1:0]      op_class,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] alu_out_q,
    output logic            cond_q,
    output logic            illegal_q
);
    localparam int SHAMT_W = $clog2(XLEN);

    op_class_e       cls;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] core_res;
    logic            core_bad;
    logic [XLEN-1:0] br_target;
    logic            br_zero;
    logic [XLEN-1:0] res_d;
    logic            cond_d;
    logic            load_en;

    // Cast the class port into the shared enum.
    always_comb cls = op_class_e'(op_class);

    ex_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
        .imm_raw (instr[IMM_W-1:0]),
        .imm_sx  (imm_sx)
    );

    ex_alu_core #(.XLEN(XLEN)) u_core (
        .cls      (cls),
        .fn_code  (instr[FN_LSB +: CODE_W]),
        .opc_code (instr[OPC_LSB +: CODE_W]),
        .shamt    (instr[SHF_LSB +: SHAMT_W]),
        .a        (opnd_a),
        .b        (opnd_b),
        .imm      (imm_sx),
        .result   (core_res),
        .bad_code (core_bad)
    );

    ex_branch_unit #(.XLEN(XLEN)) u_br (
        .npc       (npc),
        .imm       (imm_sx),
        .a         (opnd_a),
        .target    (br_target),
        .a_is_zero (br_zero)
    );

    // Pick the branch path for class 3 and mask the condition elsewhere.
    always_comb begin
        res_d   = (cls == CLS_BR) ? br_target : core_res;
        cond_d  = (cls == CLS_BR) & br_zero;
        load_en = en & ~flush;
    end

    // Output registers: reset to zero, load on enable without flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alu_out_q <= '0;
            cond_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else if (load_en) begin
            alu_out_q <= res_d;
            cond_q    <= cond_d;
            illegal_q <= core_bad;
        end
    end
endmodule

// File: rtl/ex_stage_unit_chk.sv
// Module: assertion checker for ex_stage_unit, attached with bind below.
// Assumes inputs are known at every rising edge after reset is released.
module ex_stage_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            flush,
    input logic [1:0]      op_class,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] npc,
    input logic [XLEN-1:0] alu_out_q,
    input logic            cond_q,
    input logic            illegal_q
);
    logic [XLEN-1:0] sx;
    logic            ld;

    // Checker-side view of the extended offset and load condition.
    always_comb begin
        sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
        ld = en && !flush;
    end

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(alu_out_q) && $stable(cond_q) && $stable(illegal_q)));

    // R6
    cond_non_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && op_class != 2'd3) |=> !cond_q);

    // R6
    cond_zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && op_class == 2'd3) |=> (cond_q == ($past(opnd_a) == '0)));

    // R7
    illegal_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> (alu_out_q == '0));

    // R2
    mem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && op_class == 2'd0) |=> (alu_out_q == $past(opnd_a) + $past(sx) && !illegal_q));

    // R5
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && op_class == 2'd3) |=> (alu_out_q == $past(npc) + ($past(sx) << 2) && !illegal_q));
endmodule

bind ex_stage_unit ex_stage_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .flush     (flush),
    .op_class  (op_class),
    .instr     (instr),
    .opnd_a    (opnd_a),
    .npc       (npc),
    .alu_out_q (alu_out_q),
    .cond_q    (cond_q),
    .illegal_q (illegal_q)
);

// File: tb/ex_stage_unit_bench.sv
module ex_stage_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [31:0] instr = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] npc = '0;
    logic [31:0] alu_out_q;
    logic        cond_q;
    logic        illegal_q;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_out = '0;
    logic        m_cond = 1'b0;
    logic        m_ill = 1'b0;

    always #5 clk = ~clk;

    ex_stage_unit u_ex_stage_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .op_class(op_class),
        .instr(instr), .opnd_a(opnd_a), .opnd_b(opnd_b), .npc(npc),
        .alu_out_q(alu_out_q), .cond_q(cond_q), .illegal_q(illegal_q)
    );

    function automatic logic [31:0] mk_rr(input logic [5:0] fn, input logic [4:0] sh);
        return {6'h00, 15'd0, sh, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] im);
        return {op, 10'd0, im};
    endfunction

    // Behavioural reference built from the requirement text.
    function automatic void ref_calc(input logic [1:0] cls, input logic [31:0] ins,
                                     input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] pc, output logic [31:0] r,
                                     output logic c, output logic il);
        logic [31:0] off;
        integer sa, sb, si;
        off = 32'($signed(ins[15:0]));
        sa = a; sb = b; si = off;
        r = 0; c = 0; il = 0;
        if (cls == 2'd0) r = a + off;
        else if (cls == 2'd3) begin
            r = pc + off * 4;
            c = (a == 0);
        end else if (cls == 2'd1) begin
            case (ins[5:0])
                6'h20: r = a + b;
                6'h22: r = a - b;
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h2A: r = (sa < sb) ? 1 : 0;
                6'h00: r = b << ins[10:6];
                6'h02: r = b >> ins[10:6];
                default: il = 1;
            endcase
        end else begin
            case (ins[31:26])
                6'h08: r = a + off;
                6'h0C: r = a & off;
                6'h0D: r = a | off;
                6'h0E: r = a ^ off;
                6'h0A: r = (sa < si) ? 1 : 0;
                default: il = 1;
            endcase
        end
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare at the falling edge.
    task automatic step(input string tag, input logic e, input logic f, input logic [1:0] cls,
                        input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] pc);
        logic [31:0] r;
        logic c, il;
        en = e; flush = f; op_class = cls; instr = ins; opnd_a = a; opnd_b = b; npc = pc;
        @(posedge clk);
        ref_calc(cls, ins, a, b, pc, r, c, il);
        if (!rst_n) begin
            m_out = 0; m_cond = 0; m_ill = 0;
        end else if (e && !f) begin
            m_out = r; m_cond = c; m_ill = il;
        end
        @(negedge clk);
        check(tag, "result", alu_out_q, m_out);
        check((e && !f) ? "R6" : tag, "cond", {31'd0, cond_q}, {31'd0, m_cond});
        check((e && !f) ? "R7" : tag, "illegal", {31'd0, illegal_q}, {31'd0, m_ill});
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [5:0] fns [10] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A, 6'h00, 6'h02, 6'h21, 6'h3F};
        logic [5:0] ops [7]  = '{6'h08, 6'h0C, 6'h0D, 6'h0E, 6'h0A, 6'h09, 6'h23};
        @(negedge clk);
        // R9: reset with loads requested still yields zeros
        step("R9", 1, 0, 2'd0, mk_i(6'h08, 16'h0010), 32'h1000, 0, 0);
        step("R9", 1, 0, 2'd3, mk_i(6'h04, 16'h0003), 0, 0, 32'h40);
        rst_n = 1'b1;
        // R1, R2: negative and positive offsets
        step("R1", 1, 0, 2'd0, mk_i(6'h23, 16'hFFFC), 32'h0000_1000, 0, 0);
        step("R2", 1, 0, 2'd0, mk_i(6'h2B, 16'h7FFF), 32'hFFFF_8000, 0, 0);
        // R3: each function code
        step("R3", 1, 0, 2'd1, mk_rr(6'h20, 0), 32'hFFFF_FFFF, 32'h1, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h22, 0), 32'h0, 32'h1, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h24, 0), 32'hF0F0_1234, 32'h0FF0_FFFF, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h25, 0), 32'hF000_0000, 32'h0000_000F, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h26, 0), 32'hAAAA_5555, 32'hFFFF_0000, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h2A, 0), 32'h8000_0000, 32'h1, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h2A, 0), 32'h1, 32'h8000_0000, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h00, 5'd31), 0, 32'h3, 0);
        step("R3", 1, 0, 2'd1, mk_rr(6'h02, 5'd4), 0, 32'h8000_00F0, 0);
        // R4: each opcode, sign-extended immediates
        step("R4", 1, 0, 2'd2, mk_i(6'h08, 16'h8000), 32'h1, 0, 0);
        step("R4", 1, 0, 2'd2, mk_i(6'h0C, 16'hFF00), 32'h1234_5678, 0, 0);
        step("R4", 1, 0, 2'd2, mk_i(6'h0D, 16'h00FF), 32'h1200_0000, 0, 0);
        step("R4", 1, 0, 2'd2, mk_i(6'h0E, 16'hFFFF), 32'h0F0F_0F0F, 0, 0);
        step("R4", 1, 0, 2'd2, mk_i(6'h0A, 16'hFFFF), 32'hFFFF_FFFE, 0, 0);
        // R5, R6: taken, not taken, backward wrap
        step("R5", 1, 0, 2'd3, mk_i(6'h04, 16'h0010), 32'h0, 0, 32'h0000_0100);
        step("R5", 1, 0, 2'd3, mk_i(6'h04, 16'hFFFF), 32'h5, 0, 32'h0000_0000);
        step("R6", 1, 0, 2'd0, mk_i(6'h23, 16'h0000), 32'h0, 0, 0);
        // R7: illegal codes in both ALU classes, then a legal one clears
        step("R7", 1, 0, 2'd1, mk_rr(6'h3F, 0), 32'h5, 32'h6, 0);
        step("R7", 1, 0, 2'd2, mk_i(6'h3B, 16'h0001), 32'h5, 0, 0);
        step("R7", 1, 0, 2'd1, mk_rr(6'h20, 0), 32'h5, 32'h6, 0);
        // R8: flush and disable keep earlier values
        step("R8", 1, 1, 2'd3, mk_i(6'h04, 16'h0001), 32'h0, 0, 32'h80);
        step("R8", 0, 0, 2'd1, mk_rr(6'h3F, 0), 32'h0, 0, 0);
        step("R8", 0, 1, 2'd2, mk_i(6'h08, 16'h0009), 32'h0, 0, 0);
        // Mixed pseudo-random traffic across all classes
        for (int i = 0; i < 400; i++) begin
            logic [1:0] cls;
            logic [31:0] ins, a;
            logic e, f;
            string tg;
            cls = 2'($urandom_range(0, 3));
            e = ($urandom_range(0, 5) != 0);
            f = ($urandom_range(0, 6) == 0);
            a = ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom;
            if (cls == 2'd1) ins = mk_rr(fns[$urandom_range(0, 9)], 5'($urandom));
            else if (cls == 2'd2) ins = mk_i(ops[$urandom_range(0, 6)], 16'($urandom));
            else ins = mk_i(6'h23, 16'($urandom));
            case (cls)
                2'd0: tg = "R2";
                2'd1: tg = "R3";
                2'd2: tg = "R4";
                default: tg = "R5";
            endcase
            if (!e || f) tg = "R8";
            step(tg, e, f, cls, ins, a, $urandom, $urandom);
        end
        // R9: reset in mid-run clears loaded values
        rst_n = 1'b0;
        step("R9", 1, 0, 2'd3, mk_i(6'h04, 16'h0002), 32'h0, 0, 32'h10);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule